// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM command bus and drives the power-up bring-up sequence by itself. After reset it holds the clock-enable pin low while the supply and the clock settle. It then raises clock enable with a no-operation command. It closes every bank, turns on the device's delay-locked loop, resets that loop, closes every bank again, runs a programmable number of auto-refresh cycles and writes the final operating mode. When it is finished it raises a ready flag and leaves the bus idle. From that point the normal command scheduler can take over the pins.

Every wait is a parameter counted in clock cycles: the stable-clock delay, the NOP interval after clock enable rises, precharge recovery, mode-register write spacing, refresh recovery and the delay-locked-loop lock time. The final mode word is built from three inputs: CAS latency code, burst length code and burst ordering. Between commands the bus always carries NOP. The ready flag rises only when the final mode write has settled and the lock time after the loop reset has run out.

Top module: `ddr_boot_seq`

## Requirements
- R1: While reset is asserted, and straight after it is asserted in the middle of a run, clock enable is low, the bus carries NOP (CS#=0, RAS#=1, CAS#=1, WE#=1) and the ready flag is low.
- R2: After reset is released, clock enable stays low for STABLE_CYC cycles plus the two-cycle reset synchroniser delay. It then rises and does not fall again until the next reset. While it is low, the bus carries only NOP.
- R3: The first command is precharge-all (CS#=0, RAS#=0, CAS#=1, WE#=0, A10=1, every other address bit 0, BA=0). It is issued WAKE_CYC cycles after clock enable rises.
- R4: The commands come in exactly this order: precharge-all, extended mode write, mode write with loop reset, precharge-all, REFRESH_COUNT auto-refreshes, final mode write. No other command is issued before ready.
- R5: The extended mode write drives CS#, RAS#, CAS# and WE# all low, BA=01 and an all-zero address. This enables the loop (A0=0) at full drive strength.
- R6: The loop-reset mode write drives BA=00, A8=1 and test mode A7=0. A6..A4 carry the CAS latency code, A3 the burst ordering and A2..A0 the burst length code. A12..A9 are 0.
- R7: The final mode write drives BA=00, A12..A7=0, A6..A4 from the CAS latency input (011 is 3, 110 is 2.5), A3 from the burst-ordering input (1 is interleaved) and A2..A0 from the burst length input (001 is 2, 010 is 4, 011 is 8).
- R8: The next command follows a precharge-all after TRP_CYC cycles, a mode write after TMRD_CYC cycles and an auto-refresh (CS#=0, RAS#=0, CAS#=0, WE#=1) after TRFC_CYC cycles. NOP is driven in every cycle in between. TMRD_CYC is at least 2.
- R9: The ready flag first rises in cycle max(m+TMRD_CYC, k+DLL_LOCK_CYC+1), where m is the cycle of the final mode write and k is the cycle of the loop-reset mode write.
- R10: Once ready is high, it stays high with clock enable high and the bus at NOP. Later changes on the mode inputs have no effect on the bus.
- R11: A reset during the sequence sends the sequencer back to the clock-enable-low wait. After release, the whole sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| cas_lat_i | input | 3 | CAS latency code for the mode word |
| burst_len_i | input | 3 | Burst length code for the mode word |
| burst_ilv_i | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| dram_cke_o | output | 1 | Clock enable to the device |
| dram_cs_n_o | output | 1 | Chip select, active low |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_ba_o | output | BA_W | Bank address |
| dram_addr_o | output | ADDR_W | Address bus carrying mode words and the precharge-all bit |
| init_done_o | output | 1 | Ready for normal traffic |

## Verification
The following rules are checked by properties on every cycle:
- the bus stays silent while clock enable is low, and clock enable never falls without a reset;
- every precharge-all, extended mode write and mode write carries the right address encoding;
- a mode write is always followed by NOP;
- the ready flag stays high once raised, and it cannot rise before the lock window after the loop reset has passed.

Other behaviour can only be shown by the directed scenarios:
- the exact order of commands and the exact cycle spacing between them;
- the cycle in which ready rises, on one build where the lock time is the limit and one where the final mode write is the limit;
- that mode inputs reach the final write unchanged;
- that a reset in the middle of the refresh phase restarts the whole sequence.

// File: rtl/ddr_boot_pkg.sv
package ddr_boot_pkg;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_WAKE,
    ST_PREA1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PREA2,
    ST_REFRESH,
    ST_MRS_OP,
    ST_LOCK,
    ST_READY
  } boot_step_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_REF,
    CMD_MRS
  } bus_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam int A_PREA_ALL = 10;
  localparam int A_DLL_RST  = 8;
  localparam int OP_W       = 7;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic cmd_pins_t pins_of(input bus_cmd_e c);
    cmd_pins_t p;
    unique case (c)
      CMD_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr_boot_rst_sync.sv
module ddr_boot_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/ddr_boot_timer.sv
module ddr_boot_timer #(
  parameter int WIDTH = 8,
  parameter int INIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             zero_o
);

  logic [WIDTH-1:0] cnt_q;
  logic             dec_en;

  assign dec_en = en_i && !load_i && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= WIDTH'(INIT);
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_en) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_boot_cmd_enc.sv
module ddr_boot_cmd_enc
  import ddr_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  boot_step_e        step_i,
  input  logic              issue_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_ilv_i,
  output logic              cke_o,
  output cmd_pins_t         pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [OP_W-1:0] op_word;
  bus_cmd_e        cmd;

  assign op_word = {cas_lat_i, burst_ilv_i, burst_len_i};

  always_comb begin
    cmd    = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (issue_i) begin
      unique case (step_i)
        ST_PREA1, ST_PREA2: begin
          cmd                = CMD_PREA;
          addr_o[A_PREA_ALL] = 1'b1;
        end
        ST_EMRS: begin
          cmd  = CMD_MRS;
          ba_o = BA_W'(1);
        end
        ST_MRS_DLL: begin
          cmd               = CMD_MRS;
          addr_o[OP_W-1:0]  = op_word;
          addr_o[A_DLL_RST] = 1'b1;
        end
        ST_REFRESH: begin
          cmd = CMD_REF;
        end
        ST_MRS_OP: begin
          cmd              = CMD_MRS;
          addr_o[OP_W-1:0] = op_word;
        end
        default: begin
          cmd = CMD_NOP;
        end
      endcase
    end
  end

  assign pins_o = pins_of(cmd);
  assign cke_o  = (step_i != ST_STABLE);

endmodule

// File: rtl/ddr_boot_seq.sv
module ddr_boot_seq
  import ddr_boot_pkg::*;
#(
  parameter int STABLE_CYC    = 40000,
  parameter int WAKE_CYC      = 2,
  parameter int TRP_CYC       = 3,
  parameter int TMRD_CYC      = 2,
  parameter int TRFC_CYC      = 14,
  parameter int REFRESH_COUNT = 2,
  parameter int DLL_LOCK_CYC  = 200,
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_ilv_i,
  output logic              dram_cke_o,
  output logic              dram_cs_n_o,
  output logic              dram_ras_n_o,
  output logic              dram_cas_n_o,
  output logic              dram_we_n_o,
  output logic [BA_W-1:0]   dram_ba_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic              init_done_o
);

  localparam int MAX_GAP = imax(imax(imax(STABLE_CYC, WAKE_CYC), imax(TRP_CYC, TMRD_CYC)), TRFC_CYC);
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int LOCK_W  = $clog2(DLL_LOCK_CYC + 1);
  localparam int REF_W   = $clog2(REFRESH_COUNT + 1);

  logic              rst_sync_n;
  boot_step_e        step_q, step_d;
  logic              issue_q, issue_d;
  logic [REF_W-1:0]  ref_left_q, ref_left_d;
  logic              advance;
  logic              tmr_zero, lock_zero;
  logic [CNT_W-1:0]  tmr_load_val;
  logic              lock_load, lock_en;
  cmd_pins_t         pins;

  ddr_boot_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  function automatic logic [CNT_W-1:0] dur_of(input boot_step_e s);
    unique case (s)
      ST_WAKE:              return CNT_W'(WAKE_CYC - 1);
      ST_PREA1, ST_PREA2:   return CNT_W'(TRP_CYC - 1);
      ST_EMRS, ST_MRS_DLL,
      ST_MRS_OP:            return CNT_W'(TMRD_CYC - 1);
      ST_REFRESH:           return CNT_W'(TRFC_CYC - 1);
      default:              return '0;
    endcase
  endfunction

  // next-state logic
  always_comb begin
    step_d     = step_q;
    ref_left_d = ref_left_q;
    advance    = 1'b0;
    unique case (step_q)
      ST_STABLE:  if (tmr_zero) begin step_d = ST_WAKE;    advance = 1'b1; end
      ST_WAKE:    if (tmr_zero) begin step_d = ST_PREA1;   advance = 1'b1; end
      ST_PREA1:   if (tmr_zero) begin step_d = ST_EMRS;    advance = 1'b1; end
      ST_EMRS:    if (tmr_zero) begin step_d = ST_MRS_DLL; advance = 1'b1; end
      ST_MRS_DLL: if (tmr_zero) begin step_d = ST_PREA2;   advance = 1'b1; end
      ST_PREA2: begin
        if (tmr_zero) begin
          step_d     = ST_REFRESH;
          ref_left_d = REF_W'(REFRESH_COUNT);
          advance    = 1'b1;
        end
      end
      ST_REFRESH: begin
        if (tmr_zero) begin
          ref_left_d = ref_left_q - 1'b1;
          step_d     = (ref_left_q == REF_W'(1)) ? ST_MRS_OP : ST_REFRESH;
          advance    = 1'b1;
        end
      end
      ST_MRS_OP: begin
        if (tmr_zero) begin
          step_d  = lock_zero ? ST_READY : ST_LOCK;
          advance = 1'b1;
        end
      end
      ST_LOCK:    if (lock_zero) begin step_d = ST_READY; advance = 1'b1; end
      default:    step_d = step_q;
    endcase
    issue_d = advance;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      step_q     <= ST_STABLE;
      issue_q    <= 1'b0;
      ref_left_q <= '0;
    end else begin
      step_q  <= step_d;
      issue_q <= issue_d;
      if (advance) begin
        ref_left_q <= ref_left_d;
      end
    end
  end

  assign tmr_load_val = dur_of(step_d);

  ddr_boot_timer #(
    .WIDTH (CNT_W),
    .INIT  (STABLE_CYC - 1)
  ) u_step_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (1'b1),
    .load_i     (advance),
    .load_val_i (tmr_load_val),
    .zero_o     (tmr_zero)
  );

  assign lock_load = issue_q && ((step_q == ST_EMRS) || (step_q == ST_MRS_DLL));
  assign lock_en   = step_q inside {ST_EMRS, ST_MRS_DLL, ST_PREA2, ST_REFRESH,
                                    ST_MRS_OP, ST_LOCK, ST_READY};

  ddr_boot_timer #(
    .WIDTH (LOCK_W),
    .INIT  (DLL_LOCK_CYC - 1)
  ) u_lock_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (lock_en),
    .load_i     (lock_load),
    .load_val_i (LOCK_W'(DLL_LOCK_CYC - 1)),
    .zero_o     (lock_zero)
  );

  ddr_boot_cmd_enc #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_enc (
    .step_i      (step_q),
    .issue_i     (issue_q),
    .cas_lat_i   (cas_lat_i),
    .burst_len_i (burst_len_i),
    .burst_ilv_i (burst_ilv_i),
    .cke_o       (dram_cke_o),
    .pins_o      (pins),
    .ba_o        (dram_ba_o),
    .addr_o      (dram_addr_o)
  );

  assign dram_cs_n_o  = pins.cs_n;
  assign dram_ras_n_o = pins.ras_n;
  assign dram_cas_n_o = pins.cas_n;
  assign dram_we_n_o  = pins.we_n;
  assign init_done_o  = (step_q == ST_READY);

endmodule

// File: rtl/ddr_boot_seq_chk.sv
module ddr_boot_seq_chk #(
  parameter int DLL_LOCK_CYC = 200,
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);

  localparam int SINCE_W = $clog2(DLL_LOCK_CYC + 2);

  logic               is_nop, is_pre, is_mrs, dll_rst_cmd;
  logic               dll_seen_q;
  logic [SINCE_W-1:0] since_dll_q;

  assign is_nop      = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_pre      = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign is_mrs      = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);
  assign dll_rst_cmd = is_mrs && (ba == '0) && addr[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_seen_q  <= 1'b0;
      since_dll_q <= '0;
    end else if (dll_rst_cmd) begin
      dll_seen_q  <= 1'b1;
      since_dll_q <= SINCE_W'(1);
    end else if (dll_seen_q && (since_dll_q != SINCE_W'(DLL_LOCK_CYC + 1))) begin
      since_dll_q <= since_dll_q + 1'b1;
    end
  end

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> is_nop);  // R2
  AST_CKE_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);  // R2
  AST_PREA_ALL_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (addr == (ADDR_W'(1) << 10)) && (ba == '0));  // R3
  AST_EMRS_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && (ba == BA_W'(1))) |-> (addr == '0));  // R5
  AST_MRS_TEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && (ba == '0)) |-> (!addr[7] && (addr[ADDR_W-1:9] == '0)));  // R6
  AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |=> is_nop);  // R8
  AST_DONE_LOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (dll_seen_q && (since_dll_q > SINCE_W'(DLL_LOCK_CYC))));  // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);  // R10
  AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (is_nop && cke));  // R10

endmodule

bind ddr_boot_seq ddr_boot_seq_chk #(
  .DLL_LOCK_CYC (DLL_LOCK_CYC),
  .ADDR_W       (ADDR_W),
  .BA_W         (BA_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cke   (dram_cke_o),
  .cs_n  (dram_cs_n_o),
  .ras_n (dram_ras_n_o),
  .cas_n (dram_cas_n_o),
  .we_n  (dram_we_n_o),
  .ba    (dram_ba_o),
  .addr  (dram_addr_o),
  .done  (init_done_o)
);

// File: tb/ddr_boot_seq_tb_top.sv
`timescale 1ns/1ps

module ddr_boot_mon (
  input logic        clk,
  input logic        clr,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [12:0] a,
  input logic        done
);
  int cyc, n_ev, cke_rise, done_rise, cke_low, post_cmd, cke_drop;
  logic [3:0]  ev_pins [16];
  logic [1:0]  ev_ba   [16];
  logic [12:0] ev_a    [16];
  int          ev_cyc  [16];
  logic cke_d, done_d;

  always @(negedge clk) begin
    if (clr) begin
      cyc = 0; n_ev = 0; cke_rise = -1; done_rise = -1;
      cke_low = 0; post_cmd = 0; cke_drop = 0; cke_d = 1'b0; done_d = 1'b0;
    end else begin
      cyc++;
      if (rst_n && !cke) cke_low++;
      if (cke && !cke_d && cke_rise < 0) cke_rise = cyc;
      if (!cke && cke_d) cke_drop++;
      if (done && !done_d && done_rise < 0) done_rise = cyc;
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (done) post_cmd++;
        else if (n_ev < 16) begin
          ev_pins[n_ev] = {cs_n, ras_n, cas_n, we_n};
          ev_ba[n_ev]   = ba;
          ev_a[n_ev]    = a;
          ev_cyc[n_ev]  = cyc;
          n_ev++;
        end
      end
      cke_d = cke; done_d = done;
    end
  end
endmodule

module ddr_boot_seq_tb_top;
  localparam int STABLE = 40;
  localparam int A_WAKE = 2, A_TRP = 3, A_TMRD = 2, A_TRFC = 14, A_NREF = 2, A_DLL = 200;
  localparam int B_WAKE = 1, B_TRP = 2, B_TMRD = 2, B_TRFC = 5,  B_NREF = 3, B_DLL = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, clr, bt;
  logic [2:0] cl, bl;
  logic       a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic       b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] a_ba, b_ba;
  logic [12:0] a_addr, b_addr;
  int total = 0, bad = 0;

  ddr_boot_seq #(.STABLE_CYC(STABLE), .WAKE_CYC(A_WAKE), .TRP_CYC(A_TRP), .TMRD_CYC(A_TMRD),
                 .TRFC_CYC(A_TRFC), .REFRESH_COUNT(A_NREF), .DLL_LOCK_CYC(A_DLL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cas_lat_i(cl), .burst_len_i(bl), .burst_ilv_i(bt),
    .dram_cke_o(a_cke), .dram_cs_n_o(a_cs), .dram_ras_n_o(a_ras), .dram_cas_n_o(a_cas),
    .dram_we_n_o(a_we), .dram_ba_o(a_ba), .dram_addr_o(a_addr), .init_done_o(a_done));

  ddr_boot_seq #(.STABLE_CYC(STABLE), .WAKE_CYC(B_WAKE), .TRP_CYC(B_TRP), .TMRD_CYC(B_TMRD),
                 .TRFC_CYC(B_TRFC), .REFRESH_COUNT(B_NREF), .DLL_LOCK_CYC(B_DLL)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .cas_lat_i(cl), .burst_len_i(bl), .burst_ilv_i(bt),
    .dram_cke_o(b_cke), .dram_cs_n_o(b_cs), .dram_ras_n_o(b_ras), .dram_cas_n_o(b_cas),
    .dram_we_n_o(b_we), .dram_ba_o(b_ba), .dram_addr_o(b_addr), .init_done_o(b_done));

  ddr_boot_mon mon_a (.clk(clk), .clr(clr), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
                      .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .a(a_addr), .done(a_done));
  ddr_boot_mon mon_b (.clk(clk), .clr(clr), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
                      .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .a(b_addr), .done(b_done));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_run();
    rst_n = 1'b0; clr = 1'b1;
    repeat (3) @(posedge clk);
    #1 clr = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (a_done && b_done) break;
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_seq(input int which, input int wake, input int trp, input int tmrd,
                           input int trfc, input int nref, input int dll);
    int n, cr, dr, lowc, k, m, expd, gap, exp_gap;
    logic [3:0] pins [16]; logic [1:0] bas [16]; logic [12:0] ads [16]; int cy [16];
    logic [12:0] op;
    op = {6'b0, cl, bt, bl};
    if (which == 0) begin
      n = mon_a.n_ev; cr = mon_a.cke_rise; dr = mon_a.done_rise; lowc = mon_a.cke_low;
      for (int i = 0; i < 16; i++) begin
        pins[i] = mon_a.ev_pins[i]; bas[i] = mon_a.ev_ba[i]; ads[i] = mon_a.ev_a[i]; cy[i] = mon_a.ev_cyc[i];
      end
    end else begin
      n = mon_b.n_ev; cr = mon_b.cke_rise; dr = mon_b.done_rise; lowc = mon_b.cke_low;
      for (int i = 0; i < 16; i++) begin
        pins[i] = mon_b.ev_pins[i]; bas[i] = mon_b.ev_ba[i]; ads[i] = mon_b.ev_a[i]; cy[i] = mon_b.ev_cyc[i];
      end
    end
    chk(lowc == STABLE + 2, "R2", "cke low cycles", lowc, STABLE + 2);
    chk(n == 5 + nref, "R4", "command count", n, 5 + nref);
    if (n != 5 + nref) return;
    for (int i = 0; i < n; i++) begin
      logic [3:0] ep;
      if (i == 0 || i == 3) ep = 4'b0010;
      else if (i == 1 || i == 2 || i == n - 1) ep = 4'b0000;
      else ep = 4'b0001;
      chk(pins[i] == ep, (ep == 4'b0001) ? "R8" : "R4", "command pins", pins[i], ep);
    end
    chk(cy[0] - cr == wake, "R3", "cke rise to precharge", cy[0] - cr, wake);
    chk(ads[0] == 13'h400 && bas[0] == 2'b00, "R3", "first precharge addr", ads[0], 13'h400);
    chk(ads[3] == 13'h400 && bas[3] == 2'b00, "R3", "second precharge addr", ads[3], 13'h400);
    chk(bas[1] == 2'b01 && ads[1] == 13'h000, "R5", "extended mode addr", ads[1], 0);
    chk(bas[2] == 2'b00 && ads[2] == (op | 13'h100), "R6", "loop reset word", ads[2], op | 13'h100);
    chk(bas[n-1] == 2'b00 && ads[n-1] == op, "R7", "final mode word", ads[n-1], op);
    for (int i = 1; i < n; i++) begin
      gap = cy[i] - cy[i-1];
      if (i == 1 || i == 4) exp_gap = trp;
      else if (i == 2 || i == 3) exp_gap = tmrd;
      else exp_gap = trfc;
      chk(gap == exp_gap, "R8", "command spacing", gap, exp_gap);
    end
    k = cy[2]; m = cy[n-1];
    expd = (m + tmrd > k + dll + 1) ? m + tmrd : k + dll + 1;
    chk(dr == expd, "R9", "ready rise cycle", dr, expd);
  endtask

  task automatic test_reset_state();
    rst_n = 1'b0; clr = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!a_cke && !b_cke, "R1", "cke in reset", a_cke, 0);
    chk(!a_done && !b_done, "R1", "ready in reset", a_done, 0);
    chk({a_cs, a_ras, a_cas, a_we} == 4'b0111, "R1", "bus in reset", {a_cs, a_ras, a_cas, a_we}, 4'b0111);
  endtask

  task automatic test_boot_basic();
    cl = 3'b011; bl = 3'b010; bt = 1'b0;
    start_run();
    wait_done();
    check_seq(0, A_WAKE, A_TRP, A_TMRD, A_TRFC, A_NREF, A_DLL);
    check_seq(1, B_WAKE, B_TRP, B_TMRD, B_TRFC, B_NREF, B_DLL);
  endtask

  task automatic test_boot_alt_mode();
    cl = 3'b110; bl = 3'b011; bt = 1'b1;
    start_run();
    wait_done();
    check_seq(0, A_WAKE, A_TRP, A_TMRD, A_TRFC, A_NREF, A_DLL);
    check_seq(1, B_WAKE, B_TRP, B_TMRD, B_TRFC, B_NREF, B_DLL);
  endtask

  task automatic test_after_done();
    repeat (10) @(posedge clk);
    #1 cl = 3'b001; bl = 3'b001; bt = 1'b0;
    repeat (10) @(posedge clk);
    #1 cl = 3'b111;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(mon_a.post_cmd == 0 && mon_b.post_cmd == 0, "R10", "commands after ready",
        mon_a.post_cmd + mon_b.post_cmd, 0);
    chk(a_done && b_done, "R10", "ready held", a_done, 1);
    chk(mon_a.cke_drop == 0 && mon_b.cke_drop == 0, "R2", "cke falls", mon_a.cke_drop, 0);
    chk(a_addr == 13'h0 && b_addr == 13'h0, "R10", "address idle", a_addr, 0);
  endtask

  task automatic test_reset_midway();
    cl = 3'b011; bl = 3'b001; bt = 1'b1;
    start_run();
    for (int i = 0; i < 3000; i++) begin
      if (mon_a.n_ev >= 5) break;
      @(posedge clk);
    end
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(!a_cke, "R11", "cke after mid reset", a_cke, 0);
    chk(!a_done, "R1", "ready after mid reset", a_done, 0);
    chk({a_cs, a_ras, a_cas, a_we} == 4'b0111, "R1", "bus after mid reset",
        {a_cs, a_ras, a_cas, a_we}, 4'b0111);
    start_run();
    wait_done();
    chk(mon_a.n_ev == 5 + A_NREF, "R11", "restart command count", mon_a.n_ev, 5 + A_NREF);
    check_seq(0, A_WAKE, A_TRP, A_TMRD, A_TRFC, A_NREF, A_DLL);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b1; cl = 3'b011; bl = 3'b010; bt = 1'b0;
    test_reset_state();
    test_boot_basic();
    test_after_done();
    test_boot_alt_mode();
    test_reset_midway();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
    finish_run();
  end

endmodule